// File: doc/BRIEF.md
# Two-Bank Row State Tracker

This block watches the command pins of a synchronous DRAM with two banks and keeps, for each bank, a record of whether a row is open and which row that is. A monitor or controller places it beside the memory bus: every rising clock edge it samples the active-low strobes, the bank select, a modifier bit and the row address, updates its per-bank state and shows it on its outputs one cycle later.

The tracker enforces two ordering rules on each bank separately. A bank must hold an open row before it is read or written. An open bank must be closed before it is opened again. A command that breaks either rule sets a sticky violation flag and leaves the bank state untouched. A row can be closed three ways. A single-bank close acts at once. A close of both banks acts at once. A read or write carrying the auto-close modifier marks the bank to close, and the bank actually closes when that bank's burst-complete input is raised.

Top module: `bank_row_tracker`

## Requirements
- R1: A synchronous active-high reset marks both banks closed, drives both row outputs to zero and clears the violation flag.
- R2: Pins {ras_n,cas_n,we_n} decode as 011 open-row, 101 read, 100 write, 010 close. Every other pattern (111, 110, 001, 000) changes no state and raises no violation.
- R3: An open-row command to a closed bank (bank_sel 0 or 1) opens it and captures row_addr. The new state is visible in the cycle after the edge. The other bank is unaffected.
- R4: An open-row command to a bank that is already open sets the violation flag and keeps the bank's existing row.
- R5: A read or write to a closed bank sets the violation flag and changes no bank state.
- R6: A read or write with cmd_flag=1 leaves the bank open until burst_done[bank] is high on a later edge, and the bank closes on that edge. burst_done for a bank with no close pending has no effect.
- R7: A read or write to a bank whose auto-close is pending sets the violation flag.
- R8: A close with cmd_flag=0 closes only the bank named by bank_sel and cancels any pending auto-close. Closing a bank that is already closed is legal and changes nothing.
- R9: A close with cmd_flag=1 closes both banks whatever bank_sel is, and cancels pending auto-closes.
- R10: Once set, the violation flag stays high until reset.
- R11: When a bank's burst completes on the same edge as a command to that bank, the completion is applied first. An open-row command on that edge is accepted with the new row.
- R12: The row output of a closed bank reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| bank_sel | input | 1 | Bank addressed by the command |
| cmd_flag | input | 1 | Modifier: auto-close on read/write, both banks on close |
| row_addr | input | ROW_W | Row captured by an open-row command |
| burst_done | input | 2 | Per-bank burst-complete strobe |
| bank_open | output | 2 | Per-bank open flag |
| row_bank0 | output | ROW_W | Open row of bank 0, zero when closed |
| row_bank1 | output | ROW_W | Open row of bank 1, zero when closed |
| violation | output | 1 | Sticky protocol-violation flag |

## Verification
The two functions that can fall in the same cycle are a burst completion closing a bank and a new command addressed to that bank. The bench provokes this by starting an auto-close read, then issuing an open-row command with a new row on the same edge that raises burst_done for that bank. It also raises one bank's completion while opening the other bank. Either case is judged correct only if the completion lands first: the bank shows the new row, the other bank's state is right, and the violation flag stays low.

// File: rtl/rowtrk_pkg.sv
package rowtrk_pkg;

    localparam int NUM_BANKS = 2;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_ACT   = 3'd1,
        OP_READ  = 3'd2,
        OP_WRITE = 3'd3,
        OP_DEAC  = 3'd4
    } op_e;

    typedef struct packed {
        op_e  op;
        logic bank;
        logic flag;
    } cmd_t;

    typedef struct packed {
        logic open;
        logic pend;
    } bank_st_t;

    function automatic op_e decode_pins(input logic ras_n, input logic cas_n,
                                        input logic we_n);
        op_e r;
        case ({ras_n, cas_n, we_n})
            3'b011:  r = OP_ACT;
            3'b101:  r = OP_READ;
            3'b100:  r = OP_WRITE;
            3'b010:  r = OP_DEAC;
            default: r = OP_IDLE;
        endcase
        return r;
    endfunction

    function automatic logic is_access(input op_e op);
        return (op == OP_READ) || (op == OP_WRITE);
    endfunction

endpackage

// File: rtl/rowtrk_decode.sv
module rowtrk_decode
    import rowtrk_pkg::*;
(
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic bank_sel,
    input  logic cmd_flag,
    output cmd_t cmd
);
    always_comb begin
        cmd.op   = decode_pins(ras_n, cas_n, we_n);
        cmd.bank = bank_sel;
        cmd.flag = cmd_flag;
    end
endmodule

// File: rtl/rowtrk_bank.sv
module rowtrk_bank
    import rowtrk_pkg::*;
#(
    parameter int ROW_W   = 11,
    parameter int BANK_ID = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_t             cmd,
    input  logic [ROW_W-1:0] row_in,
    input  logic             done,
    output logic             is_open,
    output logic [ROW_W-1:0] row_out,
    output logic             viol
);
    bank_st_t         st_q, st_d;
    logic [ROW_W-1:0] row_q, row_d;
    logic             sel;

    assign sel = (cmd.bank == 1'(BANK_ID));

    always_comb begin
        st_d  = st_q;
        row_d = row_q;
        viol  = 1'b0;
        // burst completion is applied before the command of the same edge
        if (st_q.pend && done) begin
            st_d.open = 1'b0;
            st_d.pend = 1'b0;
            row_d     = '0;
        end
        case (cmd.op)
            OP_ACT: begin
                if (sel) begin
                    if (st_d.open) begin
                        viol = 1'b1;
                    end else begin
                        st_d.open = 1'b1;
                        row_d     = row_in;
                    end
                end
            end
            OP_READ, OP_WRITE: begin
                if (sel) begin
                    if (!st_d.open || st_d.pend) begin
                        viol = 1'b1;
                    end else if (cmd.flag) begin
                        st_d.pend = 1'b1;
                    end
                end
            end
            OP_DEAC: begin
                if (sel || cmd.flag) begin
                    st_d.open = 1'b0;
                    st_d.pend = 1'b0;
                    row_d     = '0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            row_q <= '0;
        end else begin
            st_q  <= st_d;
            row_q <= row_d;
        end
    end

    assign is_open = st_q.open;
    assign row_out = row_q;
endmodule

// File: rtl/rowtrk_viol.sv
module rowtrk_viol #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] hit,
    output logic         flag
);
    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else if (|hit) flag <= 1'b1;
    end
endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
    import rowtrk_pkg::*;
#(
    parameter int ROW_W = 11
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic                 bank_sel,
    input  logic                 cmd_flag,
    input  logic [ROW_W-1:0]     row_addr,
    input  logic [NUM_BANKS-1:0] burst_done,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic [ROW_W-1:0]     row_bank0,
    output logic [ROW_W-1:0]     row_bank1,
    output logic                 violation
);
    cmd_t                            cmd;
    logic [NUM_BANKS-1:0]            viol_hit;
    logic [NUM_BANKS-1:0][ROW_W-1:0] rows;

    rowtrk_decode u_dec (
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .bank_sel(bank_sel),
        .cmd_flag(cmd_flag),
        .cmd     (cmd)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        rowtrk_bank #(.ROW_W(ROW_W), .BANK_ID(b)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .cmd    (cmd),
            .row_in (row_addr),
            .done   (burst_done[b]),
            .is_open(bank_open[b]),
            .row_out(rows[b]),
            .viol   (viol_hit[b])
        );
    end

    rowtrk_viol #(.N(NUM_BANKS)) u_viol (
        .clk (clk),
        .rst (rst),
        .hit (viol_hit),
        .flag(violation)
    );

    assign row_bank0 = rows[0];
    assign row_bank1 = rows[1];
endmodule

// File: rtl/bank_row_tracker_chk.sv
module bank_row_tracker_chk #(
    parameter int ROW_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             bank_sel,
    input logic             cmd_flag,
    input logic [ROW_W-1:0] row_addr,
    input logic [1:0]       burst_done,
    input logic [1:0]       bank_open,
    input logic [ROW_W-1:0] row_bank0,
    input logic [ROW_W-1:0] row_bank1,
    input logic             violation
);
    p_reset_closed_r1: assert property (@(posedge clk)
        rst |=> (bank_open == 2'b00 && !violation));

    p_act_opens_r3: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && cas_n && we_n && !bank_sel && !bank_open[0])
        |=> (bank_open[0] && row_bank0 == $past(row_addr)));

    p_act_open_viol_r4: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && cas_n && we_n && bank_sel && bank_open[1] && !burst_done[1])
        |=> violation);

    p_access_closed_r5: assert property (@(posedge clk) disable iff (rst)
        (ras_n && !cas_n && !bank_open[bank_sel]) |=> violation);

    p_close_both_r9: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && cas_n && !we_n && cmd_flag) |=> (bank_open == 2'b00));

    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        violation |=> violation);

    p_row_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (!bank_open[0] |-> row_bank0 == '0) and (!bank_open[1] |-> row_bank1 == '0));
endmodule

bind bank_row_tracker bank_row_tracker_chk #(.ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .bank_sel  (bank_sel),
    .cmd_flag  (cmd_flag),
    .row_addr  (row_addr),
    .burst_done(burst_done),
    .bank_open (bank_open),
    .row_bank0 (row_bank0),
    .row_bank1 (row_bank1),
    .violation (violation)
);

// File: tb/sim_bank_row_tracker.sv
`timescale 1ns/1ps
module sim_bank_row_tracker;
    localparam int RW = 11;
    localparam int NV = 20;
    // {pins[3], bank, flag, row[11], done[2], e_open[2], e_row0[11], e_row1[11], e_viol}
    localparam int VW = 43;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic          bank_sel = 1'b0, cmd_flag = 1'b0;
    logic [RW-1:0] row_addr = '0;
    logic [1:0]    burst_done = 2'b00;
    logic [1:0]    bank_open;
    logic [RW-1:0] row_bank0, row_bank1;
    logic          violation;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bank_row_tracker #(.ROW_W(RW)) u0 (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .bank_sel(bank_sel), .cmd_flag(cmd_flag), .row_addr(row_addr),
        .burst_done(burst_done), .bank_open(bank_open),
        .row_bank0(row_bank0), .row_bank1(row_bank1), .violation(violation)
    );

    localparam logic [VW-1:0] TBL [NV] = '{
        // R3 open bank 0, then bank 1
        {3'b011,1'b0,1'b0,11'h123,2'b00, 2'b01,11'h123,11'h000,1'b0},
        {3'b011,1'b1,1'b0,11'h2A5,2'b00, 2'b11,11'h123,11'h2A5,1'b0},
        // R2 plain read and write keep state
        {3'b101,1'b0,1'b0,11'h000,2'b00, 2'b11,11'h123,11'h2A5,1'b0},
        {3'b100,1'b1,1'b0,11'h000,2'b00, 2'b11,11'h123,11'h2A5,1'b0},
        // R2 other pin patterns do nothing
        {3'b111,1'b0,1'b0,11'h3FF,2'b00, 2'b11,11'h123,11'h2A5,1'b0},
        {3'b001,1'b0,1'b1,11'h111,2'b00, 2'b11,11'h123,11'h2A5,1'b0},
        {3'b000,1'b1,1'b1,11'h222,2'b00, 2'b11,11'h123,11'h2A5,1'b0},
        // R8 single close, then close again (legal, no change)
        {3'b010,1'b0,1'b0,11'h000,2'b00, 2'b10,11'h000,11'h2A5,1'b0},
        {3'b010,1'b0,1'b0,11'h000,2'b00, 2'b10,11'h000,11'h2A5,1'b0},
        {3'b011,1'b0,1'b0,11'h7FF,2'b00, 2'b11,11'h7FF,11'h2A5,1'b0},
        // R6 auto-close read, bank waits for completion
        {3'b101,1'b0,1'b1,11'h000,2'b00, 2'b11,11'h7FF,11'h2A5,1'b0},
        {3'b111,1'b0,1'b0,11'h000,2'b00, 2'b11,11'h7FF,11'h2A5,1'b0},
        {3'b111,1'b0,1'b0,11'h000,2'b01, 2'b10,11'h000,11'h2A5,1'b0},
        {3'b100,1'b1,1'b1,11'h000,2'b00, 2'b10,11'h000,11'h2A5,1'b0},
        // R6 completion on bank with nothing pending is ignored
        {3'b111,1'b0,1'b0,11'h000,2'b01, 2'b10,11'h000,11'h2A5,1'b0},
        // R11 bank 1 completes while bank 0 opens
        {3'b011,1'b0,1'b0,11'h001,2'b10, 2'b01,11'h001,11'h000,1'b0},
        {3'b011,1'b1,1'b0,11'h400,2'b00, 2'b11,11'h001,11'h400,1'b0},
        // R9 close both regardless of bank_sel
        {3'b010,1'b0,1'b1,11'h000,2'b00, 2'b00,11'h000,11'h000,1'b0},
        {3'b011,1'b1,1'b0,11'h055,2'b00, 2'b10,11'h000,11'h055,1'b0},
        {3'b110,1'b1,1'b0,11'h000,2'b00, 2'b10,11'h000,11'h055,1'b0}
    };

    task automatic step(input logic [2:0] pins, input logic bk, input logic fl,
                        input logic [RW-1:0] row, input logic [1:0] dn);
        {ras_n, cas_n, we_n} = pins;
        bank_sel   = bk;
        cmd_flag   = fl;
        row_addr   = row;
        burst_done = dn;
        @(posedge clk);
        #1;
        {ras_n, cas_n, we_n} = 3'b111;
        burst_done = 2'b00;
    endtask

    task automatic expect_state(input string req, input logic [1:0] e_open,
                                input logic [RW-1:0] e_r0, input logic [RW-1:0] e_r1,
                                input logic e_v);
        checks++;
        if (bank_open !== e_open || row_bank0 !== e_r0 || row_bank1 !== e_r1 ||
            violation !== e_v) begin
            errors++;
            $display("FAIL %s: got open=%b r0=%h r1=%h v=%b, expected open=%b r0=%h r1=%h v=%b",
                     req, bank_open, row_bank0, row_bank1, violation,
                     e_open, e_r0, e_r1, e_v);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        {ras_n, cas_n, we_n} = 3'b111;
        burst_done = 2'b00;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        step(3'b011, 1'b0, 1'b0, 11'h5A5, 2'b00);
        do_reset();
        expect_state("R1 reset", 2'b00, '0, '0, 1'b0);

        // table walk: R2 R3 R6 R8 R9 R11 R12
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = TBL[i];
            step(v[42:40], v[39], v[38], v[37:27], v[26:25]);
            expect_state($sformatf("R2/R3/R6/R8/R9/R11/R12 vector %0d", i),
                         v[24:23], v[22:12], v[11:1], v[0]);
        end

        // R11: same-bank completion and reopen on one edge
        do_reset();
        step(3'b011, 1'b0, 1'b0, 11'h0AA, 2'b00);
        step(3'b101, 1'b0, 1'b1, 11'h000, 2'b00);
        step(3'b011, 1'b0, 1'b0, 11'h155, 2'b01);
        expect_state("R11 reopen on completion edge", 2'b01, 11'h155, '0, 1'b0);

        // R4: open an open bank
        do_reset();
        step(3'b011, 1'b1, 1'b0, 11'h0F0, 2'b00);
        step(3'b011, 1'b1, 1'b0, 11'h00F, 2'b00);
        expect_state("R4 double open", 2'b10, '0, 11'h0F0, 1'b1);
        // R10: sticky
        step(3'b111, 1'b0, 1'b0, 11'h000, 2'b00);
        step(3'b010, 1'b1, 1'b0, 11'h000, 2'b00);
        expect_state("R10 sticky", 2'b00, '0, '0, 1'b1);
        do_reset();
        expect_state("R10 cleared by reset", 2'b00, '0, '0, 1'b0);

        // R5: read and write to closed banks
        step(3'b101, 1'b1, 1'b0, 11'h000, 2'b00);
        expect_state("R5 read closed", 2'b00, '0, '0, 1'b1);
        do_reset();
        step(3'b011, 1'b1, 1'b0, 11'h321, 2'b00);
        step(3'b100, 1'b0, 1'b1, 11'h000, 2'b00);
        expect_state("R5 write closed", 2'b10, '0, 11'h321, 1'b1);

        // R7: access while auto-close pending
        do_reset();
        step(3'b011, 1'b0, 1'b0, 11'h010, 2'b00);
        step(3'b101, 1'b0, 1'b1, 11'h000, 2'b00);
        expect_state("R7 pending, still open", 2'b01, 11'h010, '0, 1'b0);
        step(3'b100, 1'b0, 1'b0, 11'h000, 2'b00);
        expect_state("R7 access pending bank", 2'b01, 11'h010, '0, 1'b1);

        // R9/R8: close-all cancels pending auto-close
        do_reset();
        step(3'b011, 1'b0, 1'b0, 11'h00C, 2'b00);
        step(3'b011, 1'b1, 1'b0, 11'h00D, 2'b00);
        step(3'b101, 1'b0, 1'b1, 11'h000, 2'b00);
        step(3'b010, 1'b1, 1'b1, 11'h000, 2'b00);
        expect_state("R9 close all", 2'b00, '0, '0, 1'b0);
        step(3'b011, 1'b0, 1'b0, 11'h0EE, 2'b00);
        step(3'b111, 1'b0, 1'b0, 11'h000, 2'b01);
        expect_state("R9 pending cancelled", 2'b01, 11'h0EE, '0, 1'b0);
        // R8: single close cancels pending
        step(3'b101, 1'b0, 1'b1, 11'h000, 2'b00);
        step(3'b010, 1'b0, 1'b0, 11'h000, 2'b00);
        step(3'b011, 1'b0, 1'b0, 11'h0AB, 2'b00);
        step(3'b111, 1'b0, 1'b0, 11'h000, 2'b01);
        expect_state("R8 close cancels pending", 2'b01, 11'h0AB, '0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule